// File: doc/BRIEF.md
# Multi-Master Memory-Mapped Crossbar

This block joins a set of bus masters to a set of memory-mapped slaves. Each master's address goes through an address decoder that selects at most one slave. Each slave has its own round-robin arbiter. Masters that target different slaves therefore proceed in the same cycle. Masters that target the same slave are served one after another.

A granted master keeps its slave for a whole burst. The slave's stall signal, read data, read-valid and data-available signal go back only to that master. Any master that targets a busy slave stalls with its request held. An address that matches no slave is answered at once by a built-in responder.

All ports share one clock, one synchronous active-high reset, one data width and one address width. Reads are non-pipelined. A beat completes in the cycle in which read or write is asserted and the master's waitrequest is low.

Top module: `mm_crossbar`

## Requirements
- R1: Slave s is selected when `(addr & SLV_MASK[s]) == SLV_BASE[s]`. If several windows match, the lowest slave index wins. With the default parameters, slave 0 takes addresses 0x0xxx and slave 1 takes 0x1xxx (mask 0xF000).
- R2: A request whose address matches no window sees waitrequest low in the same cycle. A read of such an address returns all-ones data with readdatavalid high. A write to such an address reaches no slave.
- R3: The granted master's waitrequest follows its slave's waitrequest. The beat completes in the first cycle in which the slave drops waitrequest, so a slave that stalls for N cycles makes the beat take N+1 cycles.
- R4: Masters that target different slaves are served in the same cycles, independently of each other.
- R5: An unowned slave grants the first requesting master found when searching upward (with wrap-around) from its round-robin pointer. When a transfer finishes, the pointer moves to the master after the one that finished, modulo the number of masters.
- R6: The burst count is taken from the master on the first beat (a count of 0 counts as 1). The grant is then held until that many beats have completed.
- R7: A master whose target slave is granted to another master sees waitrequest high and readdatavalid low.
- R8: Read data, readdatavalid and data-available from a slave reach only the master granted that slave. Every other master sees data-available low.
- R9: While reset is high, no slave sees read or write asserted. Reset returns every round-robin pointer and owner to master 0 and releases every burst hold.
- R10: A slave's address, write data, byte enables, burst count, read and write are those of its granted master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all ports |
| rst | input | 1 | Synchronous reset, active high |
| m_addr | input | NM*AW | Byte address of each master |
| m_read | input | NM | Read request of each master |
| m_write | input | NM | Write request of each master |
| m_wdata | input | NM*DW | Write data of each master |
| m_be | input | NM*BEW | Byte enables of each master |
| m_burst | input | NM*BCW | Burst length of each master, taken on the first beat |
| m_wait | output | NM | Stall to each master |
| m_rdata | output | NM*DW | Read data to each master |
| m_rvalid | output | NM | Read data valid to each master |
| m_dav | output | NM | Data-available flag, forwarded from the owned slave |
| s_addr | output | NS*AW | Address to each slave |
| s_read | output | NS | Read strobe to each slave |
| s_write | output | NS | Write strobe to each slave |
| s_wdata | output | NS*DW | Write data to each slave |
| s_be | output | NS*BEW | Byte enables to each slave |
| s_burst | output | NS*BCW | Burst length to each slave |
| s_wait | input | NS | Stall from each slave |
| s_rdata | input | NS*DW | Read data from each slave |
| s_rvalid | input | NS | Read data valid from each slave |
| s_dav | input | NS | Data-available flag from each slave |

## Verification
The bench builds the crossbar with three masters and two slaves, 16-bit addresses and 32-bit data. The third master is what makes it possible to separate round-robin order from fixed priority. With it, two masters can contend for one slave while a third runs a four-beat burst on the other slave or waits behind the same burst. The two slaves are given different stall lengths, and the address space is only partly mapped. Together these expose concurrent service, wait-state forwarding and the miss responder.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    // Grant order of an arbiter: open (free to pick) or held for a burst
    typedef enum logic {
        ARB_OPEN = 1'b0,
        ARB_HELD = 1'b1
    } arb_state_e;

    // Address window match, operands zero-extended by callers
    function automatic logic win_match(logic [63:0] addr, logic [63:0] base,
                                       logic [63:0] mask);
        return ((addr & mask) == (base & mask));
    endfunction

    // First set request at or after ptr, wrapping over n entries
    function automatic int rr_first(logic [31:0] req, int ptr, int n);
        int c;
        rr_first = ptr;
        for (int k = 31; k >= 0; k--) begin
            if (k < n) begin
                c = (ptr + k) % n;
                if (req[c]) rr_first = c;
            end
        end
    endfunction

endpackage

// File: rtl/xbar_decode.sv
module xbar_decode #(
    parameter int NS = 2,
    parameter int AW = 16,
    parameter logic [NS*AW-1:0] SLV_BASE = '0,
    parameter logic [NS*AW-1:0] SLV_MASK = '0
) (
    input  logic [AW-1:0] addr,
    output logic [NS-1:0] sel_oh,
    output logic          hit
);
    always_comb begin
        sel_oh = '0;
        hit    = 1'b0;
        for (int s = NS - 1; s >= 0; s--) begin
            if (xbar_pkg::win_match(64'(addr), 64'(SLV_BASE[s*AW +: AW]),
                                    64'(SLV_MASK[s*AW +: AW]))) begin
                sel_oh    = '0;
                sel_oh[s] = 1'b1;
                hit       = 1'b1;
            end
        end
    end
endmodule

// File: rtl/xbar_arb.sv
module xbar_arb #(
    parameter int NM  = 2,
    parameter int BCW = 4,
    parameter int MIW = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NM-1:0]     req,
    input  logic [NM*BCW-1:0] bursts,
    input  logic              beat_ok,
    output logic [MIW-1:0]    gnt,
    output logic              gnt_vld,
    output logic              held
);
    import xbar_pkg::*;

    arb_state_e     st;
    logic [MIW-1:0] ptr, own, pick;
    logic [BCW-1:0] left, first_bc;
    logic           last, done;

    always_comb begin
        pick     = MIW'(rr_first(32'(req), int'(ptr), NM));
        first_bc = bursts[pick*BCW +: BCW];
        gnt      = (st == ARB_HELD) ? own : pick;
        gnt_vld  = (st == ARB_HELD) ? req[own] : |req;
        last     = (st == ARB_HELD) ? (left == BCW'(1)) : (first_bc <= BCW'(1));
        done     = gnt_vld & beat_ok;
        held     = (st == ARB_HELD);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ARB_OPEN;
            ptr  <= '0;
            own  <= '0;
            left <= '0;
        end else if (done) begin
            if (last) begin
                st  <= ARB_OPEN;
                ptr <= (gnt == MIW'(NM - 1)) ? '0 : gnt + MIW'(1);
            end else if (st == ARB_OPEN) begin
                st   <= ARB_HELD;
                own  <= pick;
                left <= first_bc - BCW'(1);
            end else begin
                left <= left - BCW'(1);
            end
        end
    end
endmodule

// File: rtl/mm_crossbar.sv
module mm_crossbar #(
    parameter int NM  = 2,
    parameter int NS  = 2,
    parameter int AW  = 16,
    parameter int DW  = 32,
    parameter int BCW = 4,
    parameter int BEW = DW / 8,
    parameter logic [NS*AW-1:0] SLV_BASE = {16'h1000, 16'h0000},
    parameter logic [NS*AW-1:0] SLV_MASK = {16'hF000, 16'hF000}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NM*AW-1:0]  m_addr,
    input  logic [NM-1:0]     m_read,
    input  logic [NM-1:0]     m_write,
    input  logic [NM*DW-1:0]  m_wdata,
    input  logic [NM*BEW-1:0] m_be,
    input  logic [NM*BCW-1:0] m_burst,
    output logic [NM-1:0]     m_wait,
    output logic [NM*DW-1:0]  m_rdata,
    output logic [NM-1:0]     m_rvalid,
    output logic [NM-1:0]     m_dav,
    output logic [NS*AW-1:0]  s_addr,
    output logic [NS-1:0]     s_read,
    output logic [NS-1:0]     s_write,
    output logic [NS*DW-1:0]  s_wdata,
    output logic [NS*BEW-1:0] s_be,
    output logic [NS*BCW-1:0] s_burst,
    input  logic [NS-1:0]     s_wait,
    input  logic [NS*DW-1:0]  s_rdata,
    input  logic [NS-1:0]     s_rvalid,
    input  logic [NS-1:0]     s_dav
);
    localparam int MIW = (NM > 1) ? $clog2(NM) : 1;

    logic [NS-1:0]     sel  [NM];
    logic [NM-1:0]     hit;
    logic [NM-1:0]     act;
    logic [NM-1:0]     req_of [NS];
    logic [NS*MIW-1:0] gnt_flat;
    logic [NS-1:0]     gnt_vld;
    logic [NS-1:0]     held;

    assign act = m_read | m_write;

    for (genvar m = 0; m < NM; m++) begin : g_dec
        xbar_decode #(.NS(NS), .AW(AW), .SLV_BASE(SLV_BASE), .SLV_MASK(SLV_MASK)) u_dec (
            .addr  (m_addr[m*AW +: AW]),
            .sel_oh(sel[m]),
            .hit   (hit[m])
        );
    end

    always_comb begin
        for (int s = 0; s < NS; s++)
            for (int m = 0; m < NM; m++)
                req_of[s][m] = act[m] & sel[m][s];
    end

    for (genvar s = 0; s < NS; s++) begin : g_arb
        xbar_arb #(.NM(NM), .BCW(BCW), .MIW(MIW)) u_arb (
            .clk    (clk),
            .rst    (rst),
            .req    (req_of[s]),
            .bursts (m_burst),
            .beat_ok(~s_wait[s]),
            .gnt    (gnt_flat[s*MIW +: MIW]),
            .gnt_vld(gnt_vld[s]),
            .held   (held[s])
        );
    end

    // Slave side: forward the granted master
    always_comb begin
        for (int s = 0; s < NS; s++) begin
            logic [MIW-1:0] g;
            g = gnt_flat[s*MIW +: MIW];
            s_addr [s*AW  +: AW]  = m_addr [g*AW  +: AW];
            s_wdata[s*DW  +: DW]  = m_wdata[g*DW  +: DW];
            s_be   [s*BEW +: BEW] = m_be   [g*BEW +: BEW];
            s_burst[s*BCW +: BCW] = m_burst[g*BCW +: BCW];
            s_read [s] = gnt_vld[s] & m_read[g]  & ~rst;
            s_write[s] = gnt_vld[s] & m_write[g] & ~rst;
        end
    end

    // Master side: owner gets slave response, misses answered locally
    always_comb begin
        for (int m = 0; m < NM; m++) begin
            m_wait[m]              = 1'b1;
            m_rdata[m*DW +: DW]    = '0;
            m_rvalid[m]            = 1'b0;
            m_dav[m]               = 1'b0;
            if (act[m] && !hit[m]) begin
                m_wait[m]           = 1'b0;
                m_rdata[m*DW +: DW] = '1;
                m_rvalid[m]         = m_read[m];
            end else begin
                for (int s = 0; s < NS; s++) begin
                    if (sel[m][s] && gnt_vld[s] &&
                        gnt_flat[s*MIW +: MIW] == MIW'(m)) begin
                        m_wait[m]           = s_wait[s];
                        m_rdata[m*DW +: DW] = s_rdata[s*DW +: DW];
                        m_rvalid[m]         = s_rvalid[s];
                        m_dav[m]            = s_dav[s];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/xbar_check.sv
module xbar_check #(
    parameter int NM  = 2,
    parameter int NS  = 2,
    parameter int AW  = 16,
    parameter int DW  = 32,
    parameter int MIW = 1,
    parameter logic [NS*AW-1:0] SLV_BASE = '0,
    parameter logic [NS*AW-1:0] SLV_MASK = '0
) (
    input logic              clk,
    input logic              rst,
    input logic [NM*AW-1:0]  m_addr,
    input logic [NM-1:0]     m_read,
    input logic [NM-1:0]     m_write,
    input logic [NM-1:0]     m_wait,
    input logic [NM*DW-1:0]  m_rdata,
    input logic [NM-1:0]     m_rvalid,
    input logic [NM-1:0]     m_dav,
    input logic [NS*AW-1:0]  s_addr,
    input logic [NS-1:0]     s_read,
    input logic [NS-1:0]     s_write,
    input logic [NS*MIW-1:0] gnt_flat,
    input logic [NS-1:0]     held
);
    int tgt [NM];

    always_comb begin
        for (int m = 0; m < NM; m++) begin
            tgt[m] = -1;
            for (int s = NS - 1; s >= 0; s--)
                if (xbar_pkg::win_match(64'(m_addr[m*AW +: AW]), 64'(SLV_BASE[s*AW +: AW]),
                                        64'(SLV_MASK[s*AW +: AW])))
                    tgt[m] = s;
        end
    end

    assert_reset_quiet_R9: assert property (@(posedge clk)
        rst |-> (s_read == '0 && s_write == '0));

    for (genvar m = 0; m < NM; m++) begin : g_m
        assert_miss_answer_R2: assert property (@(posedge clk) disable iff (rst)
            ((m_read[m] || m_write[m]) && tgt[m] < 0) |->
            (!m_wait[m] && (!m_read[m] || (m_rvalid[m] && m_rdata[m*DW +: DW] == '1))));
        assert_dav_owner_R8: assert property (@(posedge clk) disable iff (rst)
            m_dav[m] |-> (m_read[m] || m_write[m]));
        for (genvar s = 0; s < NS; s++) begin : g_s
            assert_loser_stalls_R7: assert property (@(posedge clk) disable iff (rst)
                ((m_read[m] || m_write[m]) && tgt[m] == s &&
                 gnt_flat[s*MIW +: MIW] != MIW'(m)) |-> (m_wait[m] && !m_rvalid[m]));
        end
    end

    for (genvar s = 0; s < NS; s++) begin : g_s
        assert_in_window_R1: assert property (@(posedge clk) disable iff (rst)
            (s_read[s] || s_write[s]) |->
            xbar_pkg::win_match(64'(s_addr[s*AW +: AW]), 64'(SLV_BASE[s*AW +: AW]),
                                64'(SLV_MASK[s*AW +: AW])));
        assert_burst_hold_R6: assert property (@(posedge clk) disable iff (rst)
            (held[s] && $past(held[s])) |-> $stable(gnt_flat[s*MIW +: MIW]));
    end
endmodule

bind mm_crossbar xbar_check #(
    .NM(NM), .NS(NS), .AW(AW), .DW(DW), .MIW(MIW),
    .SLV_BASE(SLV_BASE), .SLV_MASK(SLV_MASK)
) u_chk (.*);

// File: tb/mm_crossbar_test.sv
`timescale 1ns/1ps
module mm_crossbar_test;
    localparam int NM = 3, NS = 2, AW = 16, DW = 32, BCW = 4, BEW = 4;

    logic clk = 1'b0, rst = 1'b1;
    logic [NM*AW-1:0]  m_addr = '0;
    logic [NM-1:0]     m_read = '0, m_write = '0;
    logic [NM*DW-1:0]  m_wdata = '0;
    logic [NM*BEW-1:0] m_be = '1;
    logic [NM*BCW-1:0] m_burst = '0;
    logic [NM-1:0]     m_wait, m_rvalid, m_dav;
    logic [NM*DW-1:0]  m_rdata;
    logic [NS*AW-1:0]  s_addr;
    logic [NS-1:0]     s_read, s_write, s_wait, s_rvalid, s_dav;
    logic [NS*DW-1:0]  s_wdata, s_rdata;
    logic [NS*BEW-1:0] s_be;
    logic [NS*BCW-1:0] s_burst;

    mm_crossbar #(.NM(NM), .NS(NS), .AW(AW), .DW(DW), .BCW(BCW)) uut (.*);

    always #10 clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int wcfg [NS];
    int cnt  [NS];
    logic [NS-1:0] dav_val = '0;
    logic [31:0] mem [NS][64];
    logic [31:0] rd_buf [NM][8];
    int lm[$], lc[$];

    task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", rq, act, exp, cyc);
        end
    endtask

    // Behavioural slaves with programmable stall
    always_comb begin
        for (int s = 0; s < NS; s++) begin
            s_wait[s]   = (s_read[s] | s_write[s]) && (cnt[s] < wcfg[s]);
            s_rvalid[s] = s_read[s] & ~s_wait[s];
            s_rdata[s*DW +: DW] = mem[s][s_addr[s*AW+2 +: 6]];
            s_dav[s]    = dav_val[s];
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        for (int s = 0; s < NS; s++) begin
            if (s_read[s] | s_write[s]) begin
                if (s_wait[s]) cnt[s] <= cnt[s] + 1;
                else begin
                    cnt[s] <= 0;
                    if (s_write[s]) mem[s][s_addr[s*AW+2 +: 6]] <= s_wdata[s*DW +: DW];
                end
            end
        end
    end

    function automatic int dec(logic [15:0] a);
        if ((a & 16'hF000) == 16'h0000) return 0;
        if ((a & 16'hF000) == 16'h1000) return 1;
        return -1;
    endfunction

    // Reference arbitration model, compared every clock
    int ptr [NS], own [NS], left [NS];
    bit lk [NS];
    int n_ptr [NS], n_own [NS], n_left [NS];
    bit n_lk [NS];

    always @(negedge clk) begin
        #3;
        for (int s = 0; s < NS; s++) begin
            n_ptr[s] = ptr[s]; n_own[s] = own[s]; n_left[s] = left[s]; n_lk[s] = lk[s];
        end
        if (rst) begin
            chk(s_read == '0 && s_write == '0, "R9", {30'd0, s_read}, 0);
            for (int s = 0; s < NS; s++) begin
                n_ptr[s] = 0; n_own[s] = 0; n_left[s] = 0; n_lk[s] = 0;
            end
        end else begin
            for (int m = 0; m < NM; m++)
                if ((m_read[m] | m_write[m]) && dec(m_addr[m*AW +: AW]) < 0) begin
                    chk(!m_wait[m], "R2", {31'd0, m_wait[m]}, 0);
                    if (m_read[m])
                        chk(m_rvalid[m] && m_rdata[m*DW +: DW] == 32'hFFFF_FFFF, "R2",
                            m_rdata[m*DW +: DW], 32'hFFFF_FFFF);
                end
            for (int s = 0; s < NS; s++) begin
                bit rq [NM];
                int ex;
                bit any;
                any = 0;
                for (int m = 0; m < NM; m++) begin
                    rq[m] = (m_read[m] | m_write[m]) && dec(m_addr[m*AW +: AW]) == s;
                    any |= rq[m];
                end
                ex = -1;
                if (lk[s]) ex = own[s];
                else
                    for (int k = NM - 1; k >= 0; k--)
                        if (rq[(ptr[s] + k) % NM]) ex = (ptr[s] + k) % NM;
                if (!any) begin
                    chk(!s_read[s] && !s_write[s], "R10", {31'd0, s_read[s] | s_write[s]}, 0);
                end else if (ex >= 0) begin
                    chk(s_addr[s*AW +: AW] == m_addr[ex*AW +: AW] &&
                        s_write[s] == m_write[ex] && s_read[s] == m_read[ex], "R10",
                        {16'd0, s_addr[s*AW +: AW]}, {16'd0, m_addr[ex*AW +: AW]});
                    chk(m_wait[ex] == s_wait[s], "R3", {31'd0, m_wait[ex]}, {31'd0, s_wait[s]});
                    chk(m_dav[ex] == dav_val[s], "R8", {31'd0, m_dav[ex]}, {31'd0, dav_val[s]});
                    for (int m = 0; m < NM; m++)
                        if (rq[m] && m != ex)
                            chk(m_wait[m] && !m_rvalid[m] && !m_dav[m], "R7",
                                {29'd0, m_wait[m], m_rvalid[m], m_dav[m]}, 32'h4);
                    if (!s_wait[s]) begin
                        int bc;
                        bit last;
                        bc = int'(m_burst[ex*BCW +: BCW]);
                        last = lk[s] ? (left[s] == 1) : (bc <= 1);
                        if (last) begin
                            n_lk[s] = 0; n_ptr[s] = (ex + 1) % NM;
                        end else if (!lk[s]) begin
                            n_lk[s] = 1; n_own[s] = ex; n_left[s] = bc - 1;
                        end else n_left[s] = left[s] - 1;
                    end
                end
            end
        end
    end

    always @(posedge clk)
        for (int s = 0; s < NS; s++) begin
            ptr[s] <= n_ptr[s]; own[s] <= n_own[s]; left[s] <= n_left[s]; lk[s] <= n_lk[s];
        end

    // One master running nb beats; address and data step per beat
    task automatic run(int m, bit rd, logic [15:0] a, int nb, logic [31:0] d);
        for (int b = 0; b < nb; b++) begin
            m_addr[m*AW +: AW]    = a + 16'(4 * b);
            m_wdata[m*DW +: DW]   = d + 32'(b);
            m_burst[m*BCW +: BCW] = BCW'(nb);
            m_read[m]  = rd;
            m_write[m] = !rd;
            forever begin
                #2;
                if (!m_wait[m]) begin
                    if (rd) rd_buf[m][b] = m_rdata[m*DW +: DW];
                    lm.push_back(m);
                    lc.push_back(cyc);
                    @(negedge clk);
                    break;
                end
                @(negedge clk);
            end
        end
        m_read[m] = 0;
        m_write[m] = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int t0;
        for (int s = 0; s < NS; s++) begin
            cnt[s] = 0; wcfg[s] = 0;
            for (int i = 0; i < 64; i++) mem[s][i] = 32'h0;
        end
        repeat (3) @(negedge clk);
        #3 chk(m_rvalid == '0 && s_read == '0 && s_write == '0, "R9", {29'd0, m_rvalid}, 0);
        @(negedge clk) rst = 0;

        // R3: stalled write then read back from slave 0
        wcfg[0] = 2;
        lm.delete(); lc.delete(); t0 = cyc;
        run(0, 0, 16'h0010, 1, 32'hA5A5_0001);
        chk(lc[0] - t0 == 2, "R3", 32'(lc[0] - t0), 2);
        run(0, 1, 16'h0010, 1, 0);
        chk(rd_buf[0][0] == 32'hA5A5_0001, "R3", rd_buf[0][0], 32'hA5A5_0001);

        // R4: two slaves served in the same cycle
        wcfg[0] = 1; wcfg[1] = 1;
        lm.delete(); lc.delete();
        fork
            run(0, 0, 16'h0020, 1, 32'h11);
            run(1, 0, 16'h1020, 1, 32'h22);
        join
        chk(lc.size() == 2 && lc[0] == lc[1], "R4", 32'(lc[1]), 32'(lc[0]));

        // R5: round robin on slave 0 (pointer now 1)
        wcfg[0] = 0;
        lm.delete(); lc.delete();
        fork
            run(0, 0, 16'h0030, 1, 32'h30);
            run(1, 0, 16'h0034, 1, 32'h31);
        join
        chk(lm[0] == 1 && lm[1] == 0, "R5", 32'(lm[0]), 1);
        lm.delete(); lc.delete();
        fork
            run(0, 0, 16'h0038, 1, 32'h38);
            run(2, 0, 16'h003C, 1, 32'h3C);
        join
        chk(lm[0] == 2 && lm[1] == 0, "R5", 32'(lm[0]), 2);

        // R6: burst of 4 on slave 1 holds off a single write
        lm.delete(); lc.delete();
        fork
            run(2, 0, 16'h1040, 4, 32'hB000);
            run(0, 0, 16'h1080, 1, 32'hC000);
        join
        chk(lm.size() == 5 && lm[0] == 2 && lm[3] == 2 && lm[4] == 0, "R6",
            32'(lm[4]), 0);
        run(1, 1, 16'h1040, 4, 0);
        for (int b = 0; b < 4; b++)
            chk(rd_buf[1][b] == 32'hB000 + 32'(b), "R6", rd_buf[1][b], 32'hB000 + 32'(b));
        run(1, 1, 16'h1080, 1, 0);
        chk(rd_buf[1][0] == 32'hC000, "R1", rd_buf[1][0], 32'hC000);
        run(2, 1, 16'h0020, 1, 0);
        chk(rd_buf[2][0] == 32'h11, "R1", rd_buf[2][0], 32'h11);

        // R2: unmapped read and write
        lm.delete(); lc.delete(); t0 = cyc;
        run(1, 1, 16'h8000, 1, 0);
        chk(rd_buf[1][0] == 32'hFFFF_FFFF && lc[0] == t0, "R2", rd_buf[1][0], 32'hFFFF_FFFF);
        m_addr[0 +: AW] = 16'h8004; m_write[0] = 1;
        #2 chk(s_write == '0 && !m_wait[0], "R2", {30'd0, s_write}, 0);
        @(negedge clk) m_write[0] = 0;

        // R8: data-available only at the owner
        dav_val[1] = 1; wcfg[1] = 2;
        m_addr[1*AW +: AW] = 16'h1040; m_burst[1*BCW +: BCW] = 1; m_read[1] = 1;
        #2 chk(m_dav[1] && !m_dav[0] && !m_dav[2], "R8", {29'd0, m_dav}, 32'h2);
        @(negedge clk); @(negedge clk); @(negedge clk) m_read[1] = 0;
        dav_val[1] = 0;

        repeat (3) @(negedge clk);
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule